// File: doc/BRIEF.md
# Line Sensor Readout Driver

This block runs from the system clock and drives a 102-element photodiode line sensor that has only a serial start input and a clock input. It derives the sensor clock by dividing the system clock. It launches the one-bit start token and marks each pixel with a sample strobe and a pixel index, so that a downstream ADC capture knows when to convert. Every readout takes 103 sensor clock rising edges. The sensor restarts integration at the 19th edge of each readout. The driver sets the exposure by inserting extra idle sensor clocks before the next token.

Software supplies a half-period divider and an integration length counted in sensor clocks. Both are clamped to safe limits. They are sampled only while the driver is idle, so a readout in progress always finishes with the settings it started with. A frame runs for each start request, or frames repeat back to back while continuous mode is held high.

Top module: `line_sensor_driver`

## Requirements
- R1: After reset, sen_clk, sen_si, smp_valid, frame_done and busy are all low. While busy is low, sen_clk and sen_si stay low.
- R2: A frame is launched by start, or by cont_mode, only while busy is low. busy and sen_si rise on the same edge with sen_clk low. sen_si is high at rising edge 1 and falls with the falling edge that follows it. sen_si changes only while sen_clk is low. A start request while busy is ignored.
- R3: Each high phase and each low phase of sen_clk lasts D system cycles, where D is div_cfg clamped to [DIV_MIN, DIV_MAX].
- R4: In single-shot mode a frame contains exactly 103 + I sen_clk rising edges, where I is the idle count of R7, and busy stays high for 2·D·(103 + I) system cycles.
- R5: smp_valid pulses for one cycle at the sen_clk falling edge after rising edge n, for n = 1..102, with pix_idx = n − 1. There is no strobe for edge 103 or for idle edges.
- R6: frame_done pulses for one cycle at the sen_clk falling edge after rising edge 103, once per frame.
- R7: The idle count I is the clamped integration count minus 85, or zero if that is negative. The idle edges follow edge 103 inside the same busy period, so the next token is captured no earlier than edge 104 + I, counted from the previous token.
- R8: integ_cfg is clamped to [INT_MIN_CLKS, INT_MAX_CLKS] before the idle count is formed.
- R9: In continuous mode sen_si rises again at the falling edge after the last edge of a frame, busy stays high, and with I = 0 this is the same cycle as frame_done. Dropping cont_mode ends the run after the current frame.
- R10: Changes to div_cfg or integ_cfg while busy is high have no effect on the frame in progress. They take effect on the next launch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Single-frame request |
| cont_mode | input | 1 | Repeat frames while high |
| div_cfg | input | DIV_W | Sensor clock half period in system cycles |
| integ_cfg | input | INT_W | Integration length in sensor clocks |
| sen_clk | output | 1 | Sensor clock |
| sen_si | output | 1 | Sensor start token |
| smp_valid | output | 1 | ADC sample strobe |
| pix_idx | output | IDX_W | Index of the pixel being sampled |
| frame_done | output | 1 | One-cycle end-of-readout pulse |
| busy | output | 1 | Frame or idle gap in progress |

## Verification
Two events can land in the same cycle. In continuous mode with the minimum integration, the frame_done pulse of one readout and the rising start token of the next fall on the same sensor-clock falling edge. The bench provokes this by holding cont_mode high with integ_cfg at or below 85. It counts the cycles in which frame_done coincides with a rising sen_si, and it expects one such cycle per frame boundary and a single busy drop at the end. A second collision is a start request or a configuration write that arrives mid-frame. It is judged by the frame still having exactly the edge count and busy length that the original settings predict.

// File: rtl/line_sensor_driver.sv
module line_sensor_driver #(
  parameter int PIXELS       = 102,
  parameter int RESET_CLKS   = 18,
  parameter int DIV_W        = 16,
  parameter int DIV_MIN      = 25,
  parameter int DIV_MAX      = 10000,
  parameter int INT_W        = 18,
  parameter int INT_MIN_CLKS = 85,
  parameter int INT_MAX_CLKS = 200000,
  localparam int IDX_W       = $clog2(PIXELS)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             cont_mode,
  input  logic [DIV_W-1:0] div_cfg,
  input  logic [INT_W-1:0] integ_cfg,
  output logic             sen_clk,
  output logic             sen_si,
  output logic             smp_valid,
  output logic [IDX_W-1:0] pix_idx,
  output logic             frame_done,
  output logic             busy
);
  localparam int FRAME_CLKS = PIXELS + 1;
  localparam int TAIL_CLKS  = FRAME_CLKS - RESET_CLKS;
  localparam int CNT_W      = INT_W + 1;

  localparam logic [DIV_W-1:0] D_LO   = DIV_W'(DIV_MIN);
  localparam logic [DIV_W-1:0] D_HI   = DIV_W'(DIV_MAX);
  localparam logic [INT_W-1:0] I_LO   = INT_W'(INT_MIN_CLKS);
  localparam logic [INT_W-1:0] I_HI   = INT_W'(INT_MAX_CLKS);
  localparam logic [INT_W-1:0] I_TAIL = INT_W'(TAIL_CLKS);
  localparam logic [CNT_W-1:0] E_ONE  = CNT_W'(1);
  localparam logic [CNT_W-1:0] E_PIX  = CNT_W'(PIXELS);
  localparam logic [CNT_W-1:0] E_FRM  = CNT_W'(FRAME_CLKS);

  logic [DIV_W-1:0] div_cl, div_q, hcnt;
  logic [INT_W-1:0] integ_cl, idle_cl, idle_q;
  logic [CNT_W-1:0] edge_cnt, last_edge;
  logic             launch, tick, rise, fall;

  assign div_cl    = (div_cfg < D_LO) ? D_LO : (div_cfg > D_HI) ? D_HI : div_cfg;
  assign integ_cl  = (integ_cfg < I_LO) ? I_LO : (integ_cfg > I_HI) ? I_HI : integ_cfg;
  assign idle_cl   = (integ_cl > I_TAIL) ? integ_cl - I_TAIL : '0;
  assign last_edge = E_FRM + CNT_W'(idle_q);

  assign launch = !busy && (start || cont_mode);
  assign tick   = busy && (hcnt == div_q - 1'b1);
  assign rise   = tick && !sen_clk;
  assign fall   = tick && sen_clk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy       <= 1'b0;
      sen_clk    <= 1'b0;
      sen_si     <= 1'b0;
      smp_valid  <= 1'b0;
      frame_done <= 1'b0;
      pix_idx    <= '0;
      hcnt       <= '0;
      edge_cnt   <= '0;
      div_q      <= D_LO;
      idle_q     <= '0;
    end else begin
      smp_valid  <= 1'b0;
      frame_done <= 1'b0;
      if (!busy) begin
        div_q  <= div_cl;
        idle_q <= idle_cl;
      end
      if (launch) begin
        busy     <= 1'b1;
        sen_si   <= 1'b1;
        hcnt     <= '0;
        edge_cnt <= '0;
      end else if (busy) begin
        hcnt <= tick ? '0 : hcnt + 1'b1;
        if (tick) sen_clk <= !sen_clk;
        if (rise) edge_cnt <= edge_cnt + 1'b1;
        if (fall) begin
          if (edge_cnt == E_ONE) sen_si <= 1'b0;
          if (edge_cnt >= E_ONE && edge_cnt <= E_PIX) begin
            smp_valid <= 1'b1;
            pix_idx   <= IDX_W'(edge_cnt - E_ONE);
          end
          if (edge_cnt == E_FRM) frame_done <= 1'b1;
          if (edge_cnt == last_edge) begin
            if (cont_mode) begin
              sen_si   <= 1'b1;
              edge_cnt <= '0;
            end else begin
              busy <= 1'b0;
            end
          end
        end
      end
    end
  end
endmodule

// File: rtl/line_sensor_driver_chk.sv
module line_sensor_driver_chk #(
  parameter int PIXELS  = 102,
  parameter int DIV_MIN = 25,
  parameter int DIV_MAX = 10000,
  parameter int IDX_W   = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             sen_clk,
  input logic             sen_si,
  input logic             smp_valid,
  input logic [IDX_W-1:0] pix_idx,
  input logic             frame_done,
  input logic             busy
);
  logic        clk_d;
  logic [31:0] hc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_d <= 1'b0;
      hc    <= 32'd1;
    end else begin
      clk_d <= sen_clk;
      hc    <= (sen_clk != clk_d) ? 32'd1 : hc + 32'd1;
    end
  end

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!sen_clk && !sen_si && !smp_valid));

  assert_si_moves_clk_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sen_si) |-> !sen_clk);

  assert_launch_token_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (sen_si && !sen_clk));

  assert_high_phase_len_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_d && !sen_clk) |-> (hc >= 32'(DIV_MIN) && hc <= 32'(DIV_MAX)));

  assert_strobe_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
    smp_valid |-> ($fell(sen_clk) && pix_idx < IDX_W'(PIXELS)));

  assert_done_on_fall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    frame_done |-> ($fell(sen_clk) && !smp_valid));
endmodule

bind line_sensor_driver line_sensor_driver_chk #(
  .PIXELS(PIXELS), .DIV_MIN(DIV_MIN), .DIV_MAX(DIV_MAX), .IDX_W(IDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .sen_clk(sen_clk), .sen_si(sen_si),
  .smp_valid(smp_valid), .pix_idx(pix_idx), .frame_done(frame_done), .busy(busy)
);

// File: tb/line_sensor_driver_bench.sv
`timescale 1ns/1ps
module line_sensor_driver_bench;
  localparam int DW = 8;
  localparam int IW = 10;
  localparam int XW = 7;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start = 1'b0;
  logic          cont_mode = 1'b0;
  logic [DW-1:0] div_cfg = '0;
  logic [IW-1:0] integ_cfg = '0;
  logic          sen_clk, sen_si, smp_valid, frame_done, busy;
  logic [XW-1:0] pix_idx;

  always #5 clk = ~clk;

  line_sensor_driver #(
    .DIV_W(DW), .DIV_MIN(2), .DIV_MAX(6), .INT_W(IW),
    .INT_MIN_CLKS(85), .INT_MAX_CLKS(100)
  ) u_line_sensor_driver (
    .clk(clk), .rst_n(rst_n), .start(start), .cont_mode(cont_mode),
    .div_cfg(div_cfg), .integ_cfg(integ_cfg), .sen_clk(sen_clk), .sen_si(sen_si),
    .smp_valid(smp_valid), .pix_idx(pix_idx), .frame_done(frame_done), .busy(busy)
  );

  int checks = 0, errors = 0;
  int n_rise, n_smp, n_done, busy_cyc, hi_len, hi_first, idx_bad;
  int si_r1, si_late, coinc, busy_drop, exp_idx;
  logic prev_clk = 1'b0, prev_si = 1'b0, prev_busy = 1'b0;

  // {div_cfg, integ_cfg, expected half period, expected idle edges}
  localparam int NV = 5;
  localparam int VEC [NV][4] = '{
    '{1,   0, 2,  0},
    '{3,  90, 3,  5},
    '{9,  85, 6,  0},
    '{4, 500, 4, 15},
    '{2,  95, 2, 10}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic clear();
    n_rise = 0; n_smp = 0; n_done = 0; busy_cyc = 0; hi_len = 0; hi_first = 0;
    idx_bad = 0; si_r1 = 0; si_late = 0; coinc = 0; busy_drop = 0; exp_idx = 0;
  endtask

  always @(negedge clk) begin
    if (busy) busy_cyc++;
    if (sen_clk && !prev_clk) begin
      n_rise++;
      if (n_rise == 1) si_r1 = int'(sen_si);
      else if (sen_si) si_late++;
    end
    if (sen_clk) hi_len++;
    if (!sen_clk && prev_clk && hi_first == 0) hi_first = hi_len;
    if (smp_valid) begin
      if (int'(pix_idx) != exp_idx) idx_bad++;
      exp_idx++;
      n_smp++;
    end
    if (frame_done) begin
      n_done++;
      exp_idx = 0;
      if (sen_si && !prev_si) coinc++;
    end
    if (prev_busy && !busy) busy_drop++;
    prev_clk = sen_clk; prev_si = sen_si; prev_busy = busy;
  end

  task automatic wait_idle();
    while (busy) begin @(posedge clk); #1; end
    repeat (2) @(posedge clk);
    #1;
  endtask

  task automatic pulse_start();
    start = 1'b1;
    @(posedge clk); #1;
    start = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    // R1: reset state
    check("R1 sen_clk", int'(sen_clk), 0);
    check("R1 sen_si", int'(sen_si), 0);
    check("R1 busy", int'(busy), 0);
    check("R1 smp_valid", int'(smp_valid), 0);
    check("R1 frame_done", int'(frame_done), 0);
    rst_n = 1'b1;
    @(posedge clk); #1;

    for (int v = 0; v < NV; v++) begin
      int half, idle, edges;
      half = VEC[v][2]; idle = VEC[v][3]; edges = 103 + idle;
      clear();
      div_cfg = DW'(VEC[v][0]);
      integ_cfg = IW'(VEC[v][1]);
      @(posedge clk); #1;
      pulse_start();
      check("R2 busy after start", int'(busy), 1);
      wait_idle();
      check("R3 R8 high phase", hi_first, half);
      check("R4 R7 rising edges", n_rise, edges);
      check("R4 busy length", busy_cyc, 2 * half * edges);
      check("R5 strobes", n_smp, 102);
      check("R5 index order", idx_bad, 0);
      check("R6 frame_done", n_done, 1);
      check("R2 token at edge 1", si_r1, 1);
      check("R2 token cleared", si_late, 0);
    end

    // R2 R10: start and config change mid-frame are ignored
    clear();
    div_cfg = 8'd3; integ_cfg = 10'd90;
    @(posedge clk); #1;
    pulse_start();
    repeat (100) @(posedge clk);
    #1;
    div_cfg = 8'd6; integ_cfg = 10'd100;
    pulse_start();
    wait_idle();
    check("R2 restart ignored edges", n_rise, 108);
    check("R10 busy length unchanged", busy_cyc, 2 * 3 * 108);
    check("R10 half period unchanged", hi_first, 3);
    // R10: new settings apply on the next launch
    clear();
    pulse_start();
    wait_idle();
    check("R10 new half period", hi_first, 6);
    check("R10 new edge count", n_rise, 118);

    // R9: continuous mode, zero idle, frame_done meets the next token
    clear();
    div_cfg = 8'd2; integ_cfg = 10'd40;
    @(posedge clk); #1;
    cont_mode = 1'b1;
    while (n_done < 2) begin @(posedge clk); #1; end
    cont_mode = 1'b0;
    wait_idle();
    check("R9 frames", n_done, 3);
    check("R9 done meets token", coinc, 2);
    check("R9 single busy drop", busy_drop, 1);
    check("R9 edges", n_rise, 309);
    check("R9 strobes", n_smp, 306);
    check("R1 idle after run", int'(sen_clk) + int'(sen_si), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule